// File: doc/BRIEF.md
# Programmable-Priority Bus Arbiter with Parking

This block decides which of up to ten bus requesters owns the address bus. Each requester has a request line and a grant line, and is known by a 4-bit master index equal to its bit position. The order of precedence is not wired in. It comes from eight 4-bit priority slots held in two 16-bit registers. Each slot names a master index, and slot 0 outranks slot 7. When nobody eligible is requesting, the grant rests on a programmable parked master, so that this master can start a transfer without first requesting.

A granted requester keeps its grant until it signals transfer start. The arbiter then drops every grant for one cycle and decides again on the following edge. A separate data-bus grant follows transfer start. It comes either in the same cycle as transfer start or one cycle later, and only while the data bus is not busy. A control bit hands arbitration to an external arbiter. While that bit is set, this block drives no grants at all. Software programs the slots, the parked master and both mode bits through a small word-wide register port.

Top module: `bus_prio_arbiter`

## Requirements
- R1: While rst_n is low, all grant lines and the data-bus grant are low. The registers read back their reset values: address 0 gives 0x0006, address 1 gives 0x0126 and address 2 gives 0x3457.
- R2: Reads are combinational from reg_addr_i. Address 0 is the control word: bits [3:0] hold the parked master index, bit 4 selects external arbitration and bit 5 selects the delayed data grant. Bits 7:6 and everything above them read 0. Address 1 holds slots 0..3 and address 2 holds slots 4..7. Within each word the lowest slot sits in bits [15:12] and the highest in bits [3:0]. Address 3 reads 0. A write with reg_we_i high takes effect at the rising edge.
- R3: Suppose no grant is held and external arbitration is off. At the next rising edge, the eligible requester named in the lowest-numbered slot gets grant bit n, where n is its index. At most one grant bit is ever high.
- R4: If an index appears in several slots, only its lowest-numbered slot counts. A requester that appears in no slot is never granted because of its request.
- R5: Indexes 4, 5 and 10 to 15 are never granted. This holds whether they come from a slot, from the parked-master field, or from request bits 4 and 5.
- R6: A grant won by a request stays unchanged until transfer start is sampled high. At that edge all grants go low, and arbitration runs at the following edge.
- R7: Suppose no grant is held and no eligible request is pending. At the next edge the parked master's grant goes high. A parked grant is not held: it is re-evaluated at every edge.
- R8: Register writes made while a grant is held leave that grant untouched. The new values steer the next decision.
- R9: With external arbitration set, all grants are low from the next edge onward and the data-bus grant stays low.
- R10: With the delay bit at 0, the data-bus grant equals transfer start AND NOT data-busy, in the same cycle.
- R11: With the delay bit at 1, the data-bus grant is high in the cycle after transfer start was sampled, provided data-busy is low in that later cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 10 | Request line per master index |
| gnt_o | output | 10 | Address grant per master index, at most one high |
| ts_i | input | 1 | Transfer start from the current bus owner |
| dbusy_i | input | 1 | Data bus busy |
| dgnt_o | output | 1 | Data-bus grant |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data (combinational) |

## Verification
Grants are registered. A decision made from the requests and slots sampled at one rising edge shows on gnt_o just after that edge. A release caused by transfer start empties gnt_o at the sampling edge, and the new owner appears one edge later. The data-bus grant is combinational from the current inputs in the undelayed setting, and one edge late in the delayed setting. For that reason the bench checks dgnt_o shortly after it changes the inputs on the falling edge, which is the only point where the two settings give different values. It checks grants and register effects shortly after the rising edge, against a per-edge model of the slot scan, the hold and release rule and parking.

// File: rtl/arb_pkg.sv
`timescale 1ns/100ps
package arb_pkg;

   localparam int unsigned ADDR_W = 2;

   typedef enum logic [ADDR_W-1:0] {
      RA_CTRL   = 2'd0,
      RA_PRI_HI = 2'd1,
      RA_PRI_LO = 2'd2
   } reg_addr_e;

endpackage

// File: rtl/arb_regs.sv
`timescale 1ns/100ps
module arb_regs
   import arb_pkg::*;
#(
   parameter int unsigned     IDX_W      = 4,
   parameter int unsigned     REG_W      = 16,
   parameter int unsigned     NUM_FIELDS = 8,
   parameter logic [REG_W-1:0] PRI_HI_RST = '0,
   parameter logic [REG_W-1:0] PRI_LO_RST = '0,
   parameter logic [IDX_W-1:0] PARK_RST   = '0
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                we_i,
   input  logic [ADDR_W-1:0]                   addr_i,
   input  logic [REG_W-1:0]                    wdata_i,
   output logic [REG_W-1:0]                    rdata_o,
   output logic [NUM_FIELDS-1:0][IDX_W-1:0]    field_o,
   output logic [IDX_W-1:0]                    park_o,
   output logic                                ext_o,
   output logic                                dly_o
);

   localparam int unsigned FPR    = REG_W / IDX_W;
   localparam int unsigned CTRL_W = IDX_W + 2;

   if (REG_W % IDX_W != 0) begin : g_chk_div
      $error("arb_regs: REG_W must be a multiple of IDX_W");
   end
   if (NUM_FIELDS != 2 * FPR) begin : g_chk_fields
      $error("arb_regs: NUM_FIELDS must fill exactly two registers");
   end
   if (REG_W < CTRL_W) begin : g_chk_ctrl
      $error("arb_regs: control word does not fit in REG_W");
   end

   logic [REG_W-1:0]  pri_hi_q;
   logic [REG_W-1:0]  pri_lo_q;
   logic [CTRL_W-1:0] ctrl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pri_hi_q <= PRI_HI_RST;
         pri_lo_q <= PRI_LO_RST;
         ctrl_q   <= {2'b00, PARK_RST};
      end else if (we_i) begin
         case (reg_addr_e'(addr_i))
            RA_CTRL:   ctrl_q   <= wdata_i[CTRL_W-1:0];
            RA_PRI_HI: pri_hi_q <= wdata_i;
            RA_PRI_LO: pri_lo_q <= wdata_i;
            default:   ;
         endcase
      end
   end

   always_comb begin
      rdata_o = '0;
      case (reg_addr_e'(addr_i))
         RA_CTRL:   rdata_o[CTRL_W-1:0] = ctrl_q;
         RA_PRI_HI: rdata_o = pri_hi_q;
         RA_PRI_LO: rdata_o = pri_lo_q;
         default:   rdata_o = '0;
      endcase
   end

   assign park_o = ctrl_q[IDX_W-1:0];
   assign ext_o  = ctrl_q[IDX_W];
   assign dly_o  = ctrl_q[IDX_W+1];

   // slot 0 sits in the top nibble of the high word
   for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
      localparam int unsigned TOP = REG_W - 1 - IDX_W * (f % FPR);
      if (f < FPR) begin : g_hi
         assign field_o[f] = pri_hi_q[TOP -: IDX_W];
      end else begin : g_lo
         assign field_o[f] = pri_lo_q[TOP -: IDX_W];
      end
   end

endmodule

// File: rtl/arb_pick.sv
`timescale 1ns/100ps
module arb_pick #(
   parameter int unsigned NUM_FIELDS = 8,
   parameter int unsigned IDX_W      = 4
) (
   input  logic [NUM_FIELDS-1:0][IDX_W-1:0] field_i,
   input  logic [(1<<IDX_W)-1:0]            elig_i,
   output logic                             found_o,
   output logic [IDX_W-1:0]                 win_o
);

   logic [NUM_FIELDS-1:0] hit;

   for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_hit
      assign hit[f] = elig_i[field_i[f]];
   end

   // scan from the weakest slot so the strongest hit is written last
   always_comb begin
      found_o = |hit;
      win_o   = '0;
      for (int f = NUM_FIELDS - 1; f >= 0; f--) begin
         if (hit[f]) win_o = field_i[f];
      end
   end

   always_comb begin
      if (found_o) assert_win_eligible_R3: assert (elig_i[win_o]);
   end

endmodule

// File: rtl/arb_dgnt.sv
`timescale 1ns/100ps
module arb_dgnt (
   input  logic clk,
   input  logic rst_n,
   input  logic ts_i,
   input  logic dbusy_i,
   input  logic dly_i,
   input  logic ext_i,
   output logic dgnt_o
);

   logic ts_d1_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ts_d1_q <= 1'b0;
      else        ts_d1_q <= ts_i;
   end

   assign dgnt_o = rst_n && !ext_i && !dbusy_i && (dly_i ? ts_d1_q : ts_i);

   assert_dgnt_bus_free_R10: assert property (@(posedge clk) disable iff (!rst_n)
      dgnt_o |-> !dbusy_i);

   assert_dgnt_after_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (dly_i && dgnt_o) |-> $past(ts_i));

   assert_dgnt_ext_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ext_i |-> !dgnt_o);

endmodule

// File: rtl/bus_prio_arbiter.sv
`timescale 1ns/100ps
module bus_prio_arbiter
   import arb_pkg::*;
#(
   parameter int unsigned               NUM_MASTERS = 10,
   parameter int unsigned               IDX_W       = 4,
   parameter int unsigned               REG_W       = 16,
   parameter logic [NUM_MASTERS-1:0]    RSVD_MASK   = 10'b00_0011_0000,
   parameter logic [REG_W-1:0]          PRI_HI_RST  = 16'h0126,
   parameter logic [REG_W-1:0]          PRI_LO_RST  = 16'h3457,
   parameter logic [IDX_W-1:0]          PARK_RST    = 4'h6
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NUM_MASTERS-1:0] req_i,
   output logic [NUM_MASTERS-1:0] gnt_o,
   input  logic                   ts_i,
   input  logic                   dbusy_i,
   output logic                   dgnt_o,
   input  logic                   reg_we_i,
   input  logic [ADDR_W-1:0]      reg_addr_i,
   input  logic [REG_W-1:0]       reg_wdata_i,
   output logic [REG_W-1:0]       reg_rdata_o
);

   localparam int unsigned IDX_SPAN   = 1 << IDX_W;
   localparam int unsigned NUM_FIELDS = 2 * (REG_W / IDX_W);
   localparam logic [NUM_MASTERS-1:0] ONE = NUM_MASTERS'(1);

   if (NUM_MASTERS > IDX_SPAN) begin : g_chk_masters
      $error("bus_prio_arbiter: NUM_MASTERS exceeds the index space");
   end
   if (NUM_MASTERS < 2) begin : g_chk_min
      $error("bus_prio_arbiter: at least two masters required");
   end

   logic [NUM_FIELDS-1:0][IDX_W-1:0] field;
   logic [IDX_W-1:0]                 park;
   logic                             ext;
   logic                             dly;

   arb_regs #(
      .IDX_W      (IDX_W),
      .REG_W      (REG_W),
      .NUM_FIELDS (NUM_FIELDS),
      .PRI_HI_RST (PRI_HI_RST),
      .PRI_LO_RST (PRI_LO_RST),
      .PARK_RST   (PARK_RST)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (reg_we_i),
      .addr_i  (reg_addr_i),
      .wdata_i (reg_wdata_i),
      .rdata_o (reg_rdata_o),
      .field_o (field),
      .park_o  (park),
      .ext_o   (ext),
      .dly_o   (dly)
   );

   // grantable map over the full index space; reserved and out-of-range are 0
   logic [IDX_SPAN-1:0] ok_map;
   logic [IDX_SPAN-1:0] elig;

   always_comb begin
      ok_map                  = '0;
      ok_map[NUM_MASTERS-1:0] = ~RSVD_MASK;
      elig                    = '0;
      elig[NUM_MASTERS-1:0]   = req_i & ~RSVD_MASK;
   end

   logic             found;
   logic [IDX_W-1:0] win;

   arb_pick #(
      .NUM_FIELDS (NUM_FIELDS),
      .IDX_W      (IDX_W)
   ) u_pick (
      .field_i (field),
      .elig_i  (elig),
      .found_o (found),
      .win_o   (win)
   );

   logic [NUM_MASTERS-1:0] gnt_q;
   logic                   hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gnt_q  <= '0;
         hold_q <= 1'b0;
      end else if (ext) begin
         gnt_q  <= '0;
         hold_q <= 1'b0;
      end else if (hold_q) begin
         if (ts_i) begin
            gnt_q  <= '0;
            hold_q <= 1'b0;
         end
      end else if (found) begin
         gnt_q  <= ONE << win;
         hold_q <= 1'b1;
      end else if (ok_map[park]) begin
         gnt_q  <= ONE << park;
         hold_q <= 1'b0;
      end else begin
         gnt_q  <= '0;
         hold_q <= 1'b0;
      end
   end

   assign gnt_o = gnt_q;

   arb_dgnt u_dgnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .ts_i    (ts_i),
      .dbusy_i (dbusy_i),
      .dly_i   (dly),
      .ext_i   (ext),
      .dgnt_o  (dgnt_o)
   );

   assert_single_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt_o));

   assert_win_granted_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold_q && !ext && found) |=> (gnt_o != '0));

   assert_no_reserved_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_o & RSVD_MASK) == '0);

   assert_hold_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_q && !ts_i && !ext) |=> $stable(gnt_o));

   assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_q && ts_i && !ext) |=> (gnt_o == '0));

   assert_ext_no_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ext |=> (gnt_o == '0));

endmodule

// File: tb/bus_prio_arbiter_bench.sv
`timescale 1ns/100ps
module bus_prio_arbiter_bench;

   localparam int NM = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NM-1:0] req = '0;
   logic          ts = 1'b0;
   logic          dbusy = 1'b0;
   logic          reg_we = 1'b0;
   logic [1:0]    reg_addr = '0;
   logic [15:0]   reg_wdata = '0;
   logic [NM-1:0] gnt;
   logic          dgnt;
   logic [15:0]   reg_rdata;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   // model state
   logic [15:0]   m_hi  = 16'h0126;
   logic [15:0]   m_lo  = 16'h3457;
   logic [7:0]    m_ctl = 8'h06;
   logic [NM-1:0] m_gnt = '0;
   bit            m_hold = 1'b0;
   logic          m_tsd = 1'b0;

   always #2.5 clk = ~clk;

   bus_prio_arbiter u_bus_prio_arbiter (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_i       (req),
      .gnt_o       (gnt),
      .ts_i        (ts),
      .dbusy_i     (dbusy),
      .dgnt_o      (dgnt),
      .reg_we_i    (reg_we),
      .reg_addr_i  (reg_addr),
      .reg_wdata_i (reg_wdata),
      .reg_rdata_o (reg_rdata)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic bit usable(input int i);
      return i < NM && i != 4 && i != 5;
   endfunction

   function automatic int pick_m();
      for (int f = 0; f < 8; f++) begin
         logic [15:0] word = (f < 4) ? m_hi : m_lo;
         int          sh   = 12 - 4 * (f % 4);
         int          idx  = int'((word >> sh) & 16'h000F);
         if (usable(idx) && req[idx]) return idx;
      end
      return -1;
   endfunction

   function automatic logic exp_dgnt();
      if (m_ctl[4]) return 1'b0;
      if (m_ctl[5]) return m_tsd & ~dbusy;
      return ts & ~dbusy;
   endfunction

   task automatic model_edge();
      int w;
      if (m_ctl[4]) begin
         m_gnt = '0; m_hold = 1'b0;
      end else if (m_hold) begin
         if (ts) begin m_gnt = '0; m_hold = 1'b0; end
      end else begin
         w = pick_m();
         if (w >= 0) begin
            m_gnt = NM'(1) << w; m_hold = 1'b1;
         end else if (usable(int'(m_ctl[3:0]))) begin
            m_gnt = NM'(1) << m_ctl[3:0];
         end else begin
            m_gnt = '0;
         end
      end
      m_tsd = ts;
      if (reg_we) begin
         case (reg_addr)
            2'd0:    m_ctl = reg_wdata[7:0] & 8'h3F;
            2'd1:    m_hi  = reg_wdata;
            2'd2:    m_lo  = reg_wdata;
            default: ;
         endcase
      end
   endtask

   // entered at a falling edge with the inputs already set; returns at a falling edge
   task automatic step(input string tg);
      string td;
      td = m_ctl[4] ? "R9" : (m_ctl[5] ? "R11" : "R10");
      #1;
      chk(td, 32'(dgnt), 32'(exp_dgnt()));
      @(posedge clk);
      model_edge();
      #1;
      chk(tg, 32'(gnt), 32'(m_gnt));
      @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d, input string tg);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      step(tg);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, input logic [15:0] e, input string tg);
      reg_addr = a;
      #1;
      chk(tg, 32'(reg_rdata), 32'(e));
      @(negedge clk);
   endtask

   initial begin
      // R1: reset behaviour with activity on the inputs
      req = '1; ts = 1'b1;
      repeat (3) @(negedge clk);
      #1;
      chk("R1", 32'(gnt), 32'h0);
      chk("R1", 32'(dgnt), 32'h0);
      @(negedge clk);
      req = '0; ts = 1'b0;
      rd(2'd0, 16'h0006, "R1");
      rd(2'd1, 16'h0126, "R1");
      rd(2'd2, 16'h3457, "R1");
      rst_n = 1'b1;

      // R7: parked on the reset default, index 6
      step("R7");
      chk("R7", 32'(gnt), 32'h040);

      // R2: control layout, reserved bits read as zero
      wr(2'd0, 16'h00C9, "R2");
      rd(2'd0, 16'h0009, "R2");
      step("R7");
      chk("R7", 32'(gnt), 32'h200);
      wr(2'd0, 16'h0004, "R5");
      step("R5");
      chk("R5", 32'(gnt), 32'h0);
      wr(2'd0, 16'h000F, "R5");
      step("R5");
      chk("R5", 32'(gnt), 32'h0);
      wr(2'd0, 16'h0006, "R2");
      wr(2'd1, 16'hABCD, "R2");
      rd(2'd1, 16'hABCD, "R2");
      rd(2'd3, 16'h0000, "R2");
      wr(2'd1, 16'h0126, "R2");

      // R5: request bits of reserved indexes are ignored
      req = 10'h030;
      step("R5");
      chk("R5", 32'(gnt), 32'h040);
      wr(2'd1, 16'h45A0, "R5");
      req = 10'h031;
      step("R5");
      chk("R5", 32'(gnt), 32'h001);
      ts = 1'b1; req = '0;
      step("R6");
      ts = 1'b0;
      wr(2'd1, 16'h0126, "R5");

      // R3: slot 3 (index 6) beats slot 4 (index 3) and slot 7 (index 7)
      req = 10'h0C8;
      step("R3");
      chk("R3", 32'(gnt), 32'h040);

      // R6: hold until transfer start, then one empty cycle
      repeat (3) step("R6");
      req = 10'h001;
      step("R6");
      chk("R6", 32'(gnt), 32'h040);
      ts = 1'b1;
      step("R6");
      chk("R6", 32'(gnt), 32'h0);
      ts = 1'b0;
      step("R6");
      chk("R6", 32'(gnt), 32'h001);

      // R8: table rewritten mid-grant
      req = 10'h201;
      wr(2'd1, 16'h9126, "R8");
      chk("R8", 32'(gnt), 32'h001);
      step("R8");
      chk("R8", 32'(gnt), 32'h001);
      ts = 1'b1;
      step("R8");
      ts = 1'b0;
      step("R8");
      chk("R8", 32'(gnt), 32'h200);
      ts = 1'b1; req = '0;
      step("R8");
      ts = 1'b0;
      wr(2'd1, 16'h0126, "R8");

      // R4: absent requester and duplicate slots
      wr(2'd1, 16'h8888, "R4");
      wr(2'd2, 16'h8888, "R4");
      req = 10'h102;
      step("R4");
      chk("R4", 32'(gnt), 32'h100);
      ts = 1'b1;
      step("R4");
      ts = 1'b0; req = 10'h002;
      step("R4");
      chk("R4", 32'(gnt), 32'h040);
      wr(2'd1, 16'h2882, "R4");
      req = 10'h104;
      step("R4");
      chk("R4", 32'(gnt), 32'h004);
      ts = 1'b1; req = '0;
      step("R4");
      ts = 1'b0;
      wr(2'd1, 16'h0126, "R4");
      wr(2'd2, 16'h3457, "R4");

      // R9: external arbitration
      wr(2'd0, 16'h0016, "R9");
      req = '1; ts = 1'b1;
      step("R9");
      chk("R9", 32'(gnt), 32'h0);
      step("R9");
      chk("R9", 32'(dgnt), 32'h0);
      req = '0; ts = 1'b0;
      wr(2'd0, 16'h0006, "R9");

      // R10 and R11: data grant timing in both settings
      for (int d = 0; d < 2; d++) begin
         wr(2'd0, (d == 1) ? 16'h0026 : 16'h0006, (d == 1) ? "R11" : "R10");
         for (int c = 0; c < 64; c++) begin
            ts = 1'($urandom);
            dbusy = 1'($urandom);
            step((d == 1) ? "R11" : "R10");
         end
      end
      ts = 1'b0; dbusy = 1'b0;
      wr(2'd0, 16'h0006, "R10");

      // R3: every request pattern against the default table
      ts = 1'b1;
      for (int r = 0; r < 1024; r++) begin
         req = NM'(r);
         step("R3");
         step("R3");
      end
      ts = 1'b0; req = '0;
      step("R3");

      // R4: random tables, parked master and traffic
      for (int t = 0; t < 40; t++) begin
         wr(2'd1, 16'($urandom), "R4");
         wr(2'd2, 16'($urandom), "R4");
         wr(2'd0, 16'($urandom & 32'h002F), "R4");
         for (int c = 0; c < 50; c++) begin
            req = NM'($urandom) & NM'($urandom);
            ts = ($urandom % 3) == 0;
            dbusy = 1'($urandom);
            step("R4");
         end
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      #1000000;
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

endmodule